// File: doc/BRIEF.md
# I2C Clock Phase Generator

This block produces the serial clock for an I2C bus master. It drives SCL low and releases it in alternation, and it times each phase with a down-counter. The counts come from six programmable values: one high count and one low count for each of three speed modes. A two-bit speed field picks which pair is used. A run request starts the clock and stops it. A synchronised copy of the bus line is fed back in, so a slave that holds SCL low stretches the high phase. Two single-cycle strobes mark the start of each low phase and the start of each released phase. Start/stop sequencing and the data shifter sit in neighbouring logic and use these strobes.

Software must change the counts and the speed field only while the clock is not running. The block enforces this. It captures the selected pair when a run begins and ignores later changes until the next run. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `scl_timing_gen`

## Requirements
- R1: During reset, and whenever run is low, scl_o is 1 (released) and both fall_stb and rise_stb are 0.
- R2: The speed field selects the count pair: value 1 selects the standard pair, 2 the fast pair, 3 the high-speed pair, and 0 is treated as standard.
- R3: Each low phase holds scl_o at 0 for exactly lo+1 clock cycles, where lo is the selected low count.
- R4: With no stretching, each released phase lasts exactly hi+1 clock cycles, where hi is the selected high count.
- R5: The high-phase counter only counts cycles in which scl_in is 1. If scl_in stays 0 for S cycles after release, scl_o stays 1 for S+hi+1 cycles.
- R6: The count pair is captured on the cycle a run starts. Changes to the speed field or to any count while running have no effect on the phase lengths.
- R7: When run is deasserted, scl_o is 1 from the next clock edge, even in the middle of a low phase.
- R8: fall_stb is 1 only in the first cycle of each low phase, and rise_stb is 1 only in the first cycle of each released phase. The two are never 1 together.
- R9: A run always begins with a low phase on the clock edge after run is first sampled high, and the phases then alternate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Request to generate the clock |
| spd_field | input | 2 | Speed select: 0/1 standard, 2 fast, 3 high speed |
| cnt_std_hi | input | CNT_W | Standard-mode high count |
| cnt_std_lo | input | CNT_W | Standard-mode low count |
| cnt_fast_hi | input | CNT_W | Fast-mode high count |
| cnt_fast_lo | input | CNT_W | Fast-mode low count |
| cnt_hs_hi | input | CNT_W | High-speed-mode high count |
| cnt_hs_lo | input | CNT_W | High-speed-mode low count |
| scl_in | input | 1 | Synchronised level of the SCL line |
| scl_o | output | 1 | 0 drives SCL low, 1 releases it |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle of a released phase |

## Verification
The bench measures phase widths in cycles for every speed-field value, including 0. An off-by-one in the counter would show as lo or hi instead of lo+1 or hi+1, and a decoder that mapped 0 wrongly would give the widths of another mode. It holds SCL low after release and expects the released phase to grow by exactly the hold time. A counter that ran during the stretch would give too short a phase. It changes the speed and a count mid-run, drops run in the middle of a low phase, and checks the strobes' single-cycle placement. A design without capture would change width in the following period. One that waited for the phase to end would leave SCL low after run falls.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  localparam int unsigned NUM_SPD = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    SPD_STD  = 2'd0,
    SPD_FAST = 2'd1,
    SPD_HS   = 2'd2
  } spd_idx_e;

  // Field value 0 falls back to standard mode (R2)
  function automatic spd_idx_e decode_spd(input logic [1:0] field);
    case (field)
      2'd2:    decode_spd = SPD_FAST;
      2'd3:    decode_spd = SPD_HS;
      default: decode_spd = SPD_STD;
    endcase
  endfunction

endpackage

// File: rtl/scl_speed_sel.sv
module scl_speed_sel
  import scl_timing_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [1:0]                      spd_field,
  input  logic [NUM_SPD-1:0][CNT_W-1:0]   hi_tab,
  input  logic [NUM_SPD-1:0][CNT_W-1:0]   lo_tab,
  output logic [CNT_W-1:0]                hi_sel,
  output logic [CNT_W-1:0]                lo_sel
);

  spd_idx_e           idx;
  logic [NUM_SPD-1:0] hit;

  assign idx = decode_spd(spd_field);

  for (genvar g = 0; g < NUM_SPD; g++) begin : g_hit
    assign hit[g] = (int'(idx) == g);
  end

  always_comb begin
    hi_sel = '0;
    lo_sel = '0;
    for (int i = 0; i < NUM_SPD; i++) begin
      if (hit[i]) begin
        hi_sel = hi_sel | hi_tab[i];
        lo_sel = lo_sel | lo_tab[i];
      end
    end
  end

endmodule

// File: rtl/scl_down_ctr.sv
module scl_down_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero
);

  logic [W-1:0] cnt_d;
  logic [W-1:0] cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (load) cnt_d = load_val;
    else if (dec)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);

  // R3: counter never decrements through zero
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !clr && !load) |-> (cnt_q != '0));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       spd_field,
  input  logic [CNT_W-1:0] cnt_std_hi,
  input  logic [CNT_W-1:0] cnt_std_lo,
  input  logic [CNT_W-1:0] cnt_fast_hi,
  input  logic [CNT_W-1:0] cnt_fast_lo,
  input  logic [CNT_W-1:0] cnt_hs_hi,
  input  logic [CNT_W-1:0] cnt_hs_lo,
  input  logic             scl_in,
  output logic             scl_o,
  output logic             fall_stb,
  output logic             rise_stb
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // Count selection
  logic [NUM_SPD-1:0][CNT_W-1:0] hi_tab;
  logic [NUM_SPD-1:0][CNT_W-1:0] lo_tab;
  logic [CNT_W-1:0]              hi_sel;
  logic [CNT_W-1:0]              lo_sel;

  assign hi_tab = {cnt_hs_hi, cnt_fast_hi, cnt_std_hi};
  assign lo_tab = {cnt_hs_lo, cnt_fast_lo, cnt_std_lo};

  scl_speed_sel #(.CNT_W(CNT_W)) u_sel (
    .spd_field (spd_field),
    .hi_tab    (hi_tab),
    .lo_tab    (lo_tab),
    .hi_sel    (hi_sel),
    .lo_sel    (lo_sel)
  );

  // Phase control
  phase_e           state_q, state_d;
  logic [CNT_W-1:0] hi_q, lo_q;
  logic             cap;
  logic             fall_q, fall_d;
  logic             rise_q, rise_d;
  logic             ctr_clr, ctr_ld, ctr_dec, ctr_zero;
  logic [CNT_W-1:0] ctr_ld_val, ctr_cnt;

  always_comb begin
    state_d    = state_q;
    ctr_clr    = 1'b0;
    ctr_ld     = 1'b0;
    ctr_ld_val = '0;
    ctr_dec    = 1'b0;
    cap        = 1'b0;
    fall_d     = 1'b0;
    rise_d     = 1'b0;
    if (!run) begin
      state_d = PH_IDLE;
      ctr_clr = 1'b1;
    end else begin
      case (state_q)
        PH_IDLE: begin
          state_d    = PH_LOW;
          ctr_ld     = 1'b1;
          ctr_ld_val = lo_sel;
          cap        = 1'b1;
          fall_d     = 1'b1;
        end
        PH_LOW: begin
          if (ctr_zero) begin
            state_d    = PH_HIGH;
            ctr_ld     = 1'b1;
            ctr_ld_val = hi_q;
            rise_d     = 1'b1;
          end else begin
            ctr_dec = 1'b1;
          end
        end
        PH_HIGH: begin
          if (scl_in) begin
            if (ctr_zero) begin
              state_d    = PH_LOW;
              ctr_ld     = 1'b1;
              ctr_ld_val = lo_q;
              fall_d     = 1'b1;
            end else begin
              ctr_dec = 1'b1;
            end
          end
        end
        default: begin
          state_d = PH_IDLE;
          ctr_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= PH_IDLE;
      fall_q  <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fall_q  <= fall_d;
      rise_q  <= rise_d;
    end
  end

  // Shadow of the selected pair, enabled only at run start
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (cap) begin
      hi_q <= hi_sel;
      lo_q <= lo_sel;
    end
  end

  scl_down_ctr #(.W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr      (ctr_clr),
    .load     (ctr_ld),
    .load_val (ctr_ld_val),
    .dec      (ctr_dec),
    .cnt      (ctr_cnt),
    .zero     (ctr_zero)
  );

  assign scl_o    = (state_q != PH_LOW);
  assign fall_stb = fall_q;
  assign rise_stb = rise_q;

  // Assertions
  assert_idle_release_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!run) |=> (scl_o && ctr_cnt == '0));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!run) |=> (!fall_stb && !rise_stb));

  assert_low_count_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == PH_LOW && run && !ctr_zero) |=> (ctr_cnt == $past(ctr_cnt) - 1'b1));

  assert_stretch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == PH_HIGH && run && !scl_in) |=> $stable(ctr_cnt));

  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q != PH_IDLE) |=> ($stable(hi_q) && $stable(lo_q)));

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({fall_stb, rise_stb}));

  assert_fall_low_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    fall_stb |-> !scl_o);

  assert_rise_rel_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    rise_stb |-> scl_o);

  assert_high_from_low_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q != PH_HIGH && state_d == PH_HIGH) |-> (state_q == PH_LOW));

endmodule

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          run;
  logic [1:0]    spd_field;
  logic [CW-1:0] c_std_hi, c_std_lo, c_fast_hi, c_fast_lo, c_hs_hi, c_hs_lo;
  logic          stretch;
  logic          scl_in;
  logic          scl_o, fall_stb, rise_stb;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  // Bus model: line is low if either side pulls it low
  assign scl_in = scl_o & ~stretch;

  scl_timing_gen #(.CNT_W(CW)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .spd_field   (spd_field),
    .cnt_std_hi  (c_std_hi),
    .cnt_std_lo  (c_std_lo),
    .cnt_fast_hi (c_fast_hi),
    .cnt_fast_lo (c_fast_lo),
    .cnt_hs_hi   (c_hs_hi),
    .cnt_hs_lo   (c_hs_lo),
    .scl_in      (scl_in),
    .scl_o       (scl_o),
    .fall_stb    (fall_stb),
    .rise_stb    (rise_stb)
  );

  // Vector table: speed field, expected low width, expected high width (R2, R3, R4)
  localparam int NV = 4;
  localparam int V_SPD [NV] = '{0, 1, 2, 3};
  localparam int V_LO  [NV] = '{125, 125, 34, 15};
  localparam int V_HI  [NV] = '{118, 118, 22, 8};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic measure(output int lo_w, output int hi_w);
    int guard;
    guard = 0;
    lo_w  = 0;
    hi_w  = 0;
    while (scl_o && guard < 1000) begin @(negedge clk); guard++; end
    while (!scl_o && lo_w < 1000) begin lo_w++; @(negedge clk); end
    while (scl_o && hi_w < 1000) begin hi_w++; @(negedge clk); end
  endtask

  task automatic idle_cycles(input int n);
    run = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int lo_w, hi_w, low_seen;
    rst_n     = 1'b0;
    run       = 1'b0;
    stretch   = 1'b0;
    spd_field = 2'd1;
    c_std_hi  = 16'h75; c_std_lo  = 16'h7C;
    c_fast_hi = 16'h15; c_fast_lo = 16'h21;
    c_hs_hi   = 16'h07; c_hs_lo   = 16'h0E;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(scl_o == 1'b1, "R1 scl released in reset", scl_o, 1);
    chk(fall_stb == 1'b0, "R1 fall_stb in reset", fall_stb, 0);
    chk(rise_stb == 1'b0, "R1 rise_stb in reset", rise_stb, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Table walk: R2, R3, R4
    for (int v = 0; v < NV; v++) begin
      idle_cycles(3);
      spd_field = V_SPD[v][1:0];
      run = 1'b1;
      measure(lo_w, hi_w);
      chk(lo_w == V_LO[v], $sformatf("R2/R3 low width spd=%0d", V_SPD[v]), lo_w, V_LO[v]);
      chk(hi_w == V_HI[v], $sformatf("R2/R4 high width spd=%0d", V_SPD[v]), hi_w, V_HI[v]);
    end

    // R6: changes while running are ignored
    idle_cycles(3);
    spd_field = 2'd3;
    run = 1'b1;
    measure(lo_w, hi_w);
    spd_field = 2'd1;
    c_hs_lo   = 16'h30;
    measure(lo_w, hi_w);
    chk(lo_w == 15, "R6 low width after mid-run change", lo_w, 15);
    chk(hi_w == 8, "R6 high width after mid-run change", hi_w, 8);
    c_hs_lo   = 16'h0E;
    spd_field = 2'd3;

    // R8, R9: strobe placement
    idle_cycles(3);
    chk(scl_o == 1'b1 && fall_stb == 1'b0, "R1 idle between runs", scl_o, 1);
    run = 1'b1;
    @(negedge clk);
    chk(fall_stb == 1'b1 && scl_o == 1'b0, "R8/R9 fall_stb first low cycle", fall_stb, 1);
    @(negedge clk);
    chk(fall_stb == 1'b0, "R8 fall_stb single cycle", fall_stb, 0);
    while (!scl_o) @(negedge clk);
    chk(rise_stb == 1'b1, "R8 rise_stb first released cycle", rise_stb, 1);
    @(negedge clk);
    chk(rise_stb == 1'b0, "R8 rise_stb single cycle", rise_stb, 0);

    // R7: drop run in the middle of a low phase
    while (scl_o) @(negedge clk);
    repeat (3) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk(scl_o == 1'b1, "R7 released after run drop", scl_o, 1);
    low_seen = 0;
    repeat (40) begin @(negedge clk); if (!scl_o || fall_stb) low_seen++; end
    chk(low_seen == 0, "R7/R1 stays released while idle", low_seen, 0);

    // R5: slave stretches 5 cycles after release (hs mode, hi=7)
    idle_cycles(3);
    spd_field = 2'd3;
    run = 1'b1;
    while (scl_o) @(negedge clk);
    stretch = 1'b1;
    while (!scl_o) @(negedge clk);
    hi_w = 1;
    repeat (5) begin @(negedge clk); if (scl_o) hi_w++; end
    stretch = 1'b0;
    @(negedge clk);
    while (scl_o && hi_w < 1000) begin hi_w++; @(negedge clk); end
    chk(hi_w == 13, "R5 stretched released width", hi_w, 13);

    idle_cycles(2);
    finish_run();
  end

endmodule